// File: doc/BRIEF.md
# Stall-Synchronized SAR Conversion Assist

This block helps firmware run a successive-approximation conversion one bit at a time, in step with a slow analog clock. The CPU starts a conversion, writes each trial code to a DAC register, and then reads the conversion register. While a conversion is active, that read is held off with a bus stall until the next rising edge of the analog phase-1 clock. In the CPU cycle that sees that edge, the block samples the comparator and updates one bit of the code. The stall then drops and the read completes. The returned code is the next trial value. Firmware writes it back to the DAC straight away, which leaves the DAC and comparator nearly a full analog period to settle before the next phase-1 edge.

The phase-1 clock is asynchronous to the CPU clock. It passes through a two-flop synchronizer and a rising-edge detector before it can release a stalled read. The code width is a parameter. The DAC and the comparator themselves sit outside the block.

Top module: `sar_stall_assist`

## Requirements
- R1: After a synchronous active-low reset, the block is in the following state: `dac_code` is 0, `io_stall` is 0, `io_rdata` is 0, and no conversion is active, with code, trial pointer and done flag all clear.
- R2: An accepted write with `io_waddr`=1 is a start command, and its data is ignored. The following clock edge loads the code and `dac_code` with only the MSB set, points the trial pointer at the MSB, and clears done.
- R3: A read with `io_raddr`=1 while a conversion is active drives `io_stall` high until the CPU cycle in which a synchronized rising edge of `phi1` is detected. That is at most one `phi1` period plus three CPU clocks. `io_stall` is never high without `io_rd`.
- R4: In the release cycle, the comparator is sampled. A 1 keeps the trial bit and a 0 clears it, and the next lower bit is then set. `io_rdata` then reads {done at bit N+1, sampled comparator at bit N, code at bits N-1:0}. The code changes only on a start or a released step.
- R5: After N released steps, done is set and the trial pointer is empty. The final code equals the largest value whose trial the comparator accepted.
- R6: A conversion-register read while no conversion is active (after reset or after done) completes without stalling and returns {done, last comparator, code}.
- R7: An accepted write with `io_waddr`=0 loads `dac_code` from `io_wdata` at the next clock edge, and `dac_code` changes on no other write. A read with `io_raddr`=0 never stalls and returns {2'b00, dac_code}.
- R8: Writes presented while `io_stall` is high are ignored. Neither `dac_code` nor the conversion state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi1 | input | 1 | Analog phase-1 clock, asynchronous |
| cmp_in | input | 1 | Comparator decision (1: input at or above DAC) |
| io_wr | input | 1 | I/O write strobe |
| io_waddr | input | 1 | Write target: 0 DAC register, 1 start command |
| io_wdata | input | N | Write data |
| io_rd | input | 1 | I/O read request, held while stalled |
| io_raddr | input | 1 | Read target: 0 DAC register, 1 conversion register |
| io_rdata | output | N+2 | Data of the last completed read |
| io_stall | output | 1 | Bus stall, holds the current read |
| dac_code | output | N | Trial code driven to the DAC |

## Verification
The bench runs full conversions on all-zero, all-one, mid-scale and just-below-mid-scale inputs. A design with an off-by-one bit update or a misplaced done flag returns a wrong final code or sets done too early. Each stall length is measured against the `phi1` period. A design that released reads without waiting for the edge would show zero stall cycles, and one that missed edges would overrun the bound. A DAC write is pushed in the middle of a stall, which catches a design that lets it through and so corrupts the trial. Restart mid-conversion and reset mid-conversion are also covered, along with idle and finished reads that must not stall, since a design that stalled there would hang the CPU.

// File: rtl/sar_pkg.sv
// Shared address decodes for the SAR assist.
// Assumes single-bit read and write address buses.
package sar_pkg;
    localparam logic ADDR_TRIAL = 1'b0;  // DAC trial register
    localparam logic ADDR_SAR   = 1'b1;  // conversion register / start command
endpackage

// File: rtl/sar_edge_sync.sv
// Two-flop synchronizer plus rising-edge detect for the analog phase clock.
// Assumes the input is asynchronous and slow relative to clk; the pulse is one clk wide.
module sar_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [2:0] sync_q;

    // shift the asynchronous level through the synchronizer and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], async_in};
    end

    assign rise_o = sync_q[1] & ~sync_q[2];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R3
endmodule

// File: rtl/sar_step_reg.sv
// Holds the SAR code, one-hot trial pointer, done flag and last comparator bit.
// Assumes start and step are never active together (start wins if they are).
module sar_step_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         step_i,
    input  logic         cmp_i,
    output logic [N-1:0] code_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         cmp_o
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] code_q;
    logic [N-1:0] ptr_q;
    logic         done_q;
    logic         cmp_q;
    logic [N-1:0] kept;

    // keep or clear the current trial bit from the comparator decision
    always_comb begin
        kept = cmp_i ? code_q : (code_q & ~ptr_q);
    end

    // load on start, advance one bit per released step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ptr_q  <= '0;
            done_q <= 1'b0;
            cmp_q  <= 1'b0;
        end else if (start_i) begin
            code_q <= MSB_ONLY;
            ptr_q  <= MSB_ONLY;
            done_q <= 1'b0;
            cmp_q  <= 1'b0;
        end else if (step_i && busy_o) begin
            code_q <= kept | (ptr_q >> 1);
            ptr_q  <= ptr_q >> 1;
            done_q <= ptr_q[0];
            cmp_q  <= cmp_i;
        end
    end

    assign busy_o = |ptr_q;
    assign code_o = code_q;
    assign done_o = done_q;
    assign cmp_o  = cmp_q;

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q));  // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (ptr_q == '0));  // R5
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(step_i && busy_o)) |=> $stable(code_q));  // R4
endmodule

// File: rtl/sar_cpu_port.sv
// CPU-side decode: stall generation, DAC register, start/step strobes, read mux.
// Assumes the CPU holds io_rd and io_raddr steady while io_stall is high.
module sar_cpu_port #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         io_wr,
    input  logic         io_waddr,
    input  logic [N-1:0] io_wdata,
    input  logic         io_rd,
    input  logic         io_raddr,
    input  logic         rise_i,
    input  logic         busy_i,
    input  logic         done_i,
    input  logic         cmp_i,
    input  logic [N-1:0] code_i,
    output logic         io_stall,
    output logic [N+1:0] io_rdata,
    output logic [N-1:0] dac_code,
    output logic         start_o,
    output logic         step_o
);
    import sar_pkg::*;

    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic         sar_rd;
    logic         wr_ok;
    logic         rd_done;
    logic         sel_q;
    logic [N-1:0] dac_q;

    // decode stall, accepted writes and the released step
    always_comb begin
        sar_rd   = io_rd && (io_raddr == ADDR_SAR);
        io_stall = sar_rd && busy_i && !rise_i;
        wr_ok    = io_wr && !io_stall;
        start_o  = wr_ok && (io_waddr == ADDR_SAR);
        step_o   = sar_rd && busy_i && rise_i;
        rd_done  = io_rd && !io_stall;
    end

    // DAC trial register: loaded by DAC writes and by start
    always_ff @(posedge clk) begin
        if (!rst_n)                             dac_q <= '0;
        else if (start_o)                       dac_q <= MSB_ONLY;
        else if (wr_ok && io_waddr == ADDR_TRIAL) dac_q <= io_wdata;
    end

    // remember which register the last completed read selected
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= ADDR_SAR;
        else if (rd_done) sel_q <= io_raddr;
    end

    assign io_rdata = (sel_q == ADDR_SAR) ? {done_i, cmp_i, code_i} : {2'b00, dac_q};
    assign dac_code = dac_q;

    AST_STALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        io_stall |-> io_rd);  // R3
    AST_NO_WRITE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        io_stall |=> $stable(dac_q));  // R8
    AST_DAC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(dac_q));  // R7
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> !io_stall);  // R6
endmodule

// File: rtl/sar_stall_assist.sv
// Top: firmware-driven SAR assist whose conversion reads wait for the phase-1 edge.
// Assumes phi1 is asynchronous and much slower than clk; the DAC and comparator are external.
module sar_stall_assist #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phi1,
    input  logic         cmp_in,
    input  logic         io_wr,
    input  logic         io_waddr,
    input  logic [N-1:0] io_wdata,
    input  logic         io_rd,
    input  logic         io_raddr,
    output logic [N+1:0] io_rdata,
    output logic         io_stall,
    output logic [N-1:0] dac_code
);
    logic         rise;
    logic         start;
    logic         step;
    logic         busy;
    logic         done;
    logic         last_cmp;
    logic [N-1:0] code;

    sar_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (phi1),
        .rise_o   (rise)
    );

    sar_step_reg #(.N(N)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .step_i  (step),
        .cmp_i   (cmp_in),
        .code_o  (code),
        .busy_o  (busy),
        .done_o  (done),
        .cmp_o   (last_cmp)
    );

    sar_cpu_port #(.N(N)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_waddr (io_waddr),
        .io_wdata (io_wdata),
        .io_rd    (io_rd),
        .io_raddr (io_raddr),
        .rise_i   (rise),
        .busy_i   (busy),
        .done_i   (done),
        .cmp_i    (last_cmp),
        .code_i   (code),
        .io_stall (io_stall),
        .io_rdata (io_rdata),
        .dac_code (dac_code),
        .start_o  (start),
        .step_o   (step)
    );
endmodule

// File: tb/sim_sar_stall_assist.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, comparator modelled from dac_code.
module sim_sar_stall_assist;
    localparam int N = 8;
    localparam int MAX_STALL = 45;  // one phi1 period (40 clocks) plus sync margin

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         phi1 = 1'b0;
    logic         io_wr = 1'b0;
    logic         io_waddr = 1'b0;
    logic [N-1:0] io_wdata = '0;
    logic         io_rd = 1'b0;
    logic         io_raddr = 1'b0;
    logic [N+1:0] io_rdata;
    logic         io_stall;
    logic [N-1:0] dac_code;
    logic [N-1:0] vin = '0;
    logic         cmp_in;

    int n_checks = 0;
    int n_fails  = 0;

    assign cmp_in = (vin >= dac_code);

    always #2.5 clk = ~clk;  // 200 MHz
    initial begin
        #3;
        forever #100 phi1 = ~phi1;
    end

    sar_stall_assist #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .phi1(phi1), .cmp_in(cmp_in),
        .io_wr(io_wr), .io_waddr(io_waddr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_raddr(io_raddr), .io_rdata(io_rdata),
        .io_stall(io_stall), .dac_code(dac_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one write cycle, called at a negedge, returns at the next negedge
    task automatic do_write(input logic addr, input logic [N-1:0] data);
        io_wr = 1'b1; io_waddr = addr; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // read held while stalled; returns data and number of stalled cycles
    task automatic do_read(input logic addr, output logic [N+1:0] data, output int stalls);
        stalls = 0;
        io_rd = 1'b1; io_raddr = addr;
        #1;
        while (io_stall && stalls < 1000) begin
            @(negedge clk); #1;
            stalls++;
        end
        @(negedge clk);
        io_rd = 1'b0;
        #1;
        data = io_rdata;
        @(negedge clk);
    endtask

    // wait until just after a phi1 edge has been synchronized
    task automatic align_phi1;
        @(posedge phi1);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [N+1:0] d; int s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 0, "R1 dac after reset", dac_code, 0);
        check(io_stall == 0, "R1 stall after reset", io_stall, 0);
        check(io_rdata == 0, "R1 rdata after reset", io_rdata, 0);
        do_read(1'b1, d, s);
        check(s == 0, "R6 idle read stall", s, 0);
        check(d == 0, "R6 idle read data", d, 0);
    endtask

    task automatic t_convert(input logic [N-1:0] v);
        logic [N+1:0] d; int s;
        logic [N-1:0] mc, mp; logic mcmp, mdone;
        vin = v;
        align_phi1();
        do_write(1'b1, 8'h5C);
        check(dac_code == 8'h80, "R2 start loads dac MSB", dac_code, 8'h80);
        mc = 8'h80; mp = 8'h80; mdone = 1'b0;
        for (int i = 0; i < N; i++) begin
            mcmp = (v >= mc);
            if (!mcmp) mc = mc & ~mp;
            mp = mp >> 1;
            mc = mc | mp;
            mdone = (mp == 0);
            do_read(1'b1, d, s);
            check(s >= 1 && s <= MAX_STALL, "R3 stall length", s, MAX_STALL);
            check(d == {mdone, mcmp, mc}, "R4 step result", d, {mdone, mcmp, mc});
            if (!d[N+1]) do_write(1'b0, d[N-1:0]);
        end
        check(d[N+1] == 1'b1 && d[N-1:0] == v, "R5 final code and done", d, {2'b10, v});
        do_read(1'b1, d, s);
        check(s == 0, "R6 done read no stall", s, 0);
        check(d[N-1:0] == v && d[N+1], "R6 done read data", d, {2'b10, v});
    endtask

    task automatic t_dac_rw;
        logic [N+1:0] d; int s;
        do_write(1'b0, 8'hA5);
        check(dac_code == 8'hA5, "R7 dac write", dac_code, 8'hA5);
        do_read(1'b0, d, s);
        check(s == 0, "R7 dac read no stall", s, 0);
        check(d == {2'b00, 8'hA5}, "R7 dac read data", d, {2'b00, 8'hA5});
    endtask

    task automatic t_write_in_stall;
        logic [N+1:0] d; int s;
        vin = 8'h40;
        align_phi1();
        do_write(1'b1, 8'h00);
        io_rd = 1'b1; io_raddr = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(io_stall == 1, "R3 stall held", io_stall, 1);
        io_wr = 1'b1; io_waddr = 1'b0; io_wdata = 8'h33;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
        check(dac_code == 8'h80, "R8 dac write ignored in stall", dac_code, 8'h80);
        s = 0;
        while (io_stall && s < 1000) begin @(negedge clk); #1; s++; end
        @(negedge clk);
        io_rd = 1'b0;
        #1;
        d = io_rdata;
        check(d == {2'b00, 8'h60} || d == {2'b00, 8'h40},
              "R8 step uses unchanged dac", d, {2'b00, 8'h40});
        check(d[N-1:0] == 8'h40, "R4 cleared MSB then set next", d, 8'h40);
        @(negedge clk);
    endtask

    task automatic t_restart_and_reset;
        logic [N+1:0] d; int s;
        vin = 8'hFF;
        align_phi1();
        do_write(1'b1, 8'h00);
        do_read(1'b1, d, s);
        do_write(1'b0, d[N-1:0]);
        do_write(1'b1, 8'h00);
        check(dac_code == 8'h80, "R2 restart reloads dac", dac_code, 8'h80);
        do_read(1'b1, d, s);
        check(d == {2'b01, 8'hC0}, "R2 restart begins at MSB", d, {2'b01, 8'hC0});
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 0, "R1 reset mid conversion", dac_code, 0);
        do_read(1'b1, d, s);
        check(s == 0 && d == 0, "R1 reset clears conversion", d, 0);
    endtask

    initial begin
        #500000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_dac_rw();
        t_convert(8'h00);
        t_convert(8'hFF);
        t_convert(8'h80);
        t_convert(8'h7F);
        t_convert(8'h5A);
        t_write_in_stall();
        t_restart_and_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule